// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block turns one exception request into the complete set of architectural updates a processor makes on exception entry. From the request type and the current machine state it produces, all in one go, the handler address to redirect fetch to, the value to save as the return address, the updated cause register word (code, delay-slot flag, coprocessor number) and the new values of the three status flags that govern exception level, error level and the boot-time vector location.

Requests arrive on a valid/ready input. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The request fields must be held stable while `req_valid` is high. The machine-state inputs are sampled on the same edge. `req_ready` is low for exactly the cycle in which the results are presented, so a new request can only be taken after the strobe. The results are registered and appear with a one-cycle `redirect` strobe on the cycle after acceptance. The write enables pulse together with that strobe. There is no back-pressure on the output side: the consumer must take the results in the strobe cycle.

Request kind encoding (`req_kind`): for an ordinary exception the kind value equals the 5-bit cause code to be recorded. The codes are: 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address error on load, 5 address error on store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating point and 30 cache error. The value 31 denotes a non-maskable interrupt. The cause register layout relied on is: code in bits 6:2, coprocessor number in bits 29:28, delay-slot flag in bit 31.

Top module: `exc_vector_unit`

## Requirements
- R1: `req_ready` is high whenever `redirect` is low and low while `redirect` is high. A request accepted on an edge makes `redirect` high for exactly the following cycle, and `redirect` is low in every cycle that does not follow an acceptance.
- R2: For every kind other than 31, `cause_we` pulses with the strobe and `cause_wdata[6:2]` equals the kind. Bits 27:7, 1:0 and 30 are copied unchanged from `cause_in`.
- R3: The handler base is 0xBFC00200 when `st_bev` is set. Otherwise it is `ebase` with bits 9:0 cleared. The handler address `new_pc` is base plus offset.
- R4: The offset is 0x180 for every ordinary kind not covered by R5, R6 or R11. A TLB load or TLB store with `req_refill` set and `st_exl` clear uses offset 0x000. With `st_exl` set, a refill uses 0x180.
- R5: An interrupt (kind 0) with `vec_en` clear uses offset 0x200 when `cause_iv` is set and 0x180 otherwise.
- R6: An interrupt with `vec_en` set uses offset 0x200 + v × (`vec_spacing` × 32). Here v is the highest-numbered line from 7 down to 1 that is both pending and unmasked, or 0 if there is none. Line 0 never selects a vector.
- R7: With `st_exl` clear, an ordinary exception pulses `epc_we`, and `epc_wdata` is the resume PC. Cause bit 31 is set to `in_delay_slot`, and `exl_o` is 1.
- R8: With `st_exl` set, an ordinary exception does not pulse `epc_we`, leaves cause bit 31 as in `cause_in`, and keeps `exl_o` at 1.
- R9: The resume PC is `cur_pc` − 4 when `in_delay_slot` is set and `cur_pc` otherwise.
- R10: A kind 31 request pulses `errpc_we` with the resume PC in `errpc_wdata`. It sets `erl_o` and `bev_o`, redirects to 0xBFC00000, does not write EPC or cause, and passes `st_exl` through to `exl_o`.
- R11: A cache error (kind 30) uses offset 0x100 when `st_bev` is set and 0x20000100 otherwise, with code 30.
- R12: For kind 11 the `cop_num` input is written into cause bits 29:28. For any other kind those bits are copied from `cause_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 5 | Request kind (cause code, or 31 for non-maskable interrupt) |
| req_refill | input | 1 | TLB miss with no matching entry (refill) |
| cop_num | input | 2 | Coprocessor number for coprocessor-unusable |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction sits in a branch delay slot |
| st_exl | input | 1 | Current exception-level flag |
| st_erl | input | 1 | Current error-level flag |
| st_bev | input | 1 | Current boot-vector flag |
| ebase | input | 32 | Exception base register |
| cause_in | input | 32 | Current cause register |
| cause_iv | input | 1 | Dedicated interrupt vector select |
| vec_en | input | 1 | Vectored interrupt mode enable |
| vec_spacing | input | 5 | Vector spacing field |
| irq_pending | input | 8 | Pending interrupt lines |
| irq_mask | input | 8 | Interrupt enable mask |
| redirect | output | 1 | One-cycle strobe: results valid |
| new_pc | output | 32 | Handler address |
| epc_we | output | 1 | Write exception return register |
| epc_wdata | output | 32 | Exception return value |
| errpc_we | output | 1 | Write error return register |
| errpc_wdata | output | 32 | Error return value |
| cause_we | output | 1 | Write cause register |
| cause_wdata | output | 32 | New cause register value |
| exl_o | output | 1 | New exception-level flag |
| erl_o | output | 1 | New error-level flag |
| bev_o | output | 1 | New boot-vector flag |

## Verification
On every cycle the assertions check the handshake shape: a single-cycle strobe that always follows an acceptance, with ready low during it. On every strobe they check that the recorded cause code matches the accepted kind, that the return value equals the sampled PC adjusted for the delay slot, that no EPC write happens when the exception level was already set, and that an error-return write always comes with the fixed reset-style vector and both error and boot flags set. Handler address arithmetic needs directed scenarios from the bench. That covers base selection, refill offsets, interrupt vector priority and spacing, cache-error offsets, and preservation of unrelated cause bits.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int AW = 32;

  localparam logic [4:0] KIND_IRQ       = 5'd0;
  localparam logic [4:0] KIND_TLB_LOAD  = 5'd2;
  localparam logic [4:0] KIND_TLB_STORE = 5'd3;
  localparam logic [4:0] KIND_COP_UNUSE = 5'd11;
  localparam logic [4:0] KIND_CACHE_ERR = 5'd30;
  localparam logic [4:0] KIND_NMI       = 5'd31;

  localparam int CAUSE_EC_LSB = 2;
  localparam int CAUSE_CE_LSB = 28;
  localparam int CAUSE_BD_BIT = 31;

  localparam logic [AW-1:0] BOOT_BASE    = 32'hBFC0_0200;
  localparam logic [AW-1:0] NMI_VECTOR   = 32'hBFC0_0000;
  localparam logic [AW-1:0] OFF_GENERAL  = 32'h0000_0180;
  localparam logic [AW-1:0] OFF_REFILL   = 32'h0000_0000;
  localparam logic [AW-1:0] OFF_IRQ      = 32'h0000_0200;
  localparam logic [AW-1:0] OFF_CERR_BEV = 32'h0000_0100;
  localparam logic [AW-1:0] OFF_CERR     = 32'h2000_0100;

  typedef struct packed {
    logic [AW-1:0] new_pc;
    logic          epc_we;
    logic [AW-1:0] epc_wdata;
    logic          errpc_we;
    logic [AW-1:0] errpc_wdata;
    logic          cause_we;
    logic [AW-1:0] cause_wdata;
    logic          exl;
    logic          erl;
    logic          bev;
  } exc_result_t;
endpackage

// File: rtl/exc_irq_vector.sv
module exc_irq_vector #(
  parameter int LINES = 8,
  localparam int VW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] pending,
  input  logic [LINES-1:0] mask,
  output logic [VW-1:0]    vec
);
  logic [LINES-1:0] live;
  assign live = pending & mask;

  // Ascending scan: the last live line found (the highest) wins; line 0 never selects.
  always_comb begin
    vec = '0;
    for (int i = 1; i < LINES; i++) begin
      if (live[i]) vec = VW'(i);
    end
  end
endmodule

// File: rtl/exc_offset_sel.sv
module exc_offset_sel
  import exc_vec_pkg::*;
#(
  parameter int VW        = 3,
  parameter int SPACING_W = 5
) (
  input  logic [4:0]           kind,
  input  logic                 refill,
  input  logic                 exl,
  input  logic                 bev,
  input  logic                 iv,
  input  logic                 vec_en,
  input  logic [VW-1:0]        vec,
  input  logic [SPACING_W-1:0] spacing,
  output logic [AW-1:0]        offset
);
  logic [AW-1:0] step;
  assign step = AW'(spacing) << 5;

  always_comb begin
    offset = OFF_GENERAL;
    unique case (kind)
      KIND_IRQ: begin
        if (vec_en)  offset = OFF_IRQ + AW'(vec) * step;
        else if (iv) offset = OFF_IRQ;
      end
      KIND_TLB_LOAD, KIND_TLB_STORE: begin
        if (refill && !exl) offset = OFF_REFILL;
      end
      KIND_CACHE_ERR: offset = bev ? OFF_CERR_BEV : OFF_CERR;
      default: offset = OFF_GENERAL;
    endcase
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int IRQ_LINES = 8,
  parameter int SPACING_W = 5,
  localparam int VW = (IRQ_LINES > 1) ? $clog2(IRQ_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [4:0]           req_kind,
  input  logic                 req_refill,
  input  logic [1:0]           cop_num,
  input  logic [31:0]          cur_pc,
  input  logic                 in_delay_slot,
  input  logic                 st_exl,
  input  logic                 st_erl,
  input  logic                 st_bev,
  input  logic [31:0]          ebase,
  input  logic [31:0]          cause_in,
  input  logic                 cause_iv,
  input  logic                 vec_en,
  input  logic [SPACING_W-1:0] vec_spacing,
  input  logic [IRQ_LINES-1:0] irq_pending,
  input  logic [IRQ_LINES-1:0] irq_mask,
  output logic                 redirect,
  output logic [31:0]          new_pc,
  output logic                 epc_we,
  output logic [31:0]          epc_wdata,
  output logic                 errpc_we,
  output logic [31:0]          errpc_wdata,
  output logic                 cause_we,
  output logic [31:0]          cause_wdata,
  output logic                 exl_o,
  output logic                 erl_o,
  output logic                 bev_o
);
  logic [VW-1:0] vec;
  logic [AW-1:0] offset;
  logic [AW-1:0] base;
  logic [AW-1:0] resume_pc;
  logic          is_nmi;
  logic          accept;
  exc_result_t   nxt, res_q;
  logic          strobe_q;

  exc_irq_vector #(.LINES(IRQ_LINES)) u_vec (
    .pending (irq_pending),
    .mask    (irq_mask),
    .vec     (vec)
  );

  exc_offset_sel #(.VW(VW), .SPACING_W(SPACING_W)) u_off (
    .kind    (req_kind),
    .refill  (req_refill),
    .exl     (st_exl),
    .bev     (st_bev),
    .iv      (cause_iv),
    .vec_en  (vec_en),
    .vec     (vec),
    .spacing (vec_spacing),
    .offset  (offset)
  );

  assign is_nmi    = (req_kind == KIND_NMI);
  assign base      = st_bev ? BOOT_BASE : {ebase[AW-1:10], 10'b0};
  assign resume_pc = in_delay_slot ? (cur_pc - 32'd4) : cur_pc;
  assign req_ready = ~strobe_q;
  assign accept    = req_valid & req_ready;

  always_comb begin
    nxt             = '0;
    nxt.cause_wdata = cause_in;
    nxt.exl         = st_exl;
    nxt.erl         = st_erl;
    nxt.bev         = st_bev;
    if (is_nmi) begin
      nxt.new_pc      = NMI_VECTOR;
      nxt.errpc_we    = 1'b1;
      nxt.errpc_wdata = resume_pc;
      nxt.erl         = 1'b1;
      nxt.bev         = 1'b1;
    end else begin
      nxt.new_pc   = base + offset;
      nxt.cause_we = 1'b1;
      nxt.cause_wdata[CAUSE_EC_LSB +: 5] = req_kind;
      if (req_kind == KIND_COP_UNUSE)
        nxt.cause_wdata[CAUSE_CE_LSB +: 2] = cop_num;
      if (!st_exl) begin
        nxt.epc_we    = 1'b1;
        nxt.epc_wdata = resume_pc;
        nxt.cause_wdata[CAUSE_BD_BIT] = in_delay_slot;
      end
      nxt.exl = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      res_q    <= '0;
    end else begin
      strobe_q <= accept;
      if (accept) res_q <= nxt;
      else begin
        res_q.epc_we   <= 1'b0;
        res_q.errpc_we <= 1'b0;
        res_q.cause_we <= 1'b0;
      end
    end
  end

  assign redirect    = strobe_q;
  assign new_pc      = res_q.new_pc;
  assign epc_we      = res_q.epc_we;
  assign epc_wdata   = res_q.epc_wdata;
  assign errpc_we    = res_q.errpc_we;
  assign errpc_wdata = res_q.errpc_wdata;
  assign cause_we    = res_q.cause_we;
  assign cause_wdata = res_q.cause_wdata;
  assign exl_o       = res_q.exl;
  assign erl_o       = res_q.erl;
  assign bev_o       = res_q.bev;
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [4:0]  req_kind,
  input logic [31:0] cur_pc,
  input logic        in_delay_slot,
  input logic        st_exl,
  input logic        redirect,
  input logic [31:0] new_pc,
  input logic        epc_we,
  input logic [31:0] epc_wdata,
  input logic        errpc_we,
  input logic        erl_o,
  input logic        bev_o,
  input logic        cause_we,
  input logic [31:0] cause_wdata
);
  a_r1_ready_low_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> !req_ready);
  a_r1_accept_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> redirect);
  a_r1_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !redirect);
  a_r2_code_matches_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && cause_we) |-> (cause_wdata[6:2] == $past(req_kind)));
  a_r8_no_epc_when_exl: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && $past(st_exl)) |-> !epc_we);
  a_r9_epc_resume: assert property (@(posedge clk) disable iff (!rst_n)
    epc_we |-> (epc_wdata == ($past(in_delay_slot) ? $past(cur_pc) - 32'd4 : $past(cur_pc))));
  a_r10_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    errpc_we |-> (new_pc == 32'hBFC0_0000 && erl_o && bev_o && !epc_we && !cause_we));
  a_r7_we_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (epc_we || errpc_we || cause_we) |-> redirect);
endmodule

bind exc_vector_unit exc_vector_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .cur_pc(cur_pc), .in_delay_slot(in_delay_slot),
  .st_exl(st_exl), .redirect(redirect), .new_pc(new_pc), .epc_we(epc_we),
  .epc_wdata(epc_wdata), .errpc_we(errpc_we), .erl_o(erl_o), .bev_o(bev_o),
  .cause_we(cause_we), .cause_wdata(cause_wdata)
);

// File: tb/exc_vector_unit_bench.sv
module exc_vector_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_ready, req_refill = 0, in_delay_slot = 0;
  logic [4:0]  req_kind = 0, vec_spacing = 0;
  logic [1:0]  cop_num = 0;
  logic [31:0] cur_pc = 0, ebase = 32'h8000_0000, cause_in = 0;
  logic        st_exl = 0, st_erl = 0, st_bev = 0, cause_iv = 0, vec_en = 0;
  logic [7:0]  irq_pending = 0, irq_mask = 0;
  logic        redirect, epc_we, errpc_we, cause_we, exl_o, erl_o, bev_o;
  logic [31:0] new_pc, epc_wdata, errpc_wdata, cause_wdata;

  int checks = 0, failures = 0;

  exc_vector_unit u_exc_vector_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_refill(req_refill), .cop_num(cop_num),
    .cur_pc(cur_pc), .in_delay_slot(in_delay_slot), .st_exl(st_exl),
    .st_erl(st_erl), .st_bev(st_bev), .ebase(ebase), .cause_in(cause_in),
    .cause_iv(cause_iv), .vec_en(vec_en), .vec_spacing(vec_spacing),
    .irq_pending(irq_pending), .irq_mask(irq_mask), .redirect(redirect),
    .new_pc(new_pc), .epc_we(epc_we), .epc_wdata(epc_wdata),
    .errpc_we(errpc_we), .errpc_wdata(errpc_wdata), .cause_we(cause_we),
    .cause_wdata(cause_wdata), .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request; returns at the falling edge of the strobe cycle.
  task automatic issue(input logic [4:0] kind, input logic [31:0] pc, input logic ds,
                       input logic refill);
    @(negedge clk);
    req_kind = kind; cur_pc = pc; in_delay_slot = ds; req_refill = refill;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset redirect", {31'b0, redirect}, 32'd0);
    check("R1 reset ready", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_syscall;
    issue(5'd8, 32'h0000_1000, 1'b0, 1'b0);
    check("R1 strobe", {31'b0, redirect}, 32'd1);
    check("R1 ready low", {31'b0, req_ready}, 32'd0);
    check("R4 general pc", new_pc, 32'h8000_0180);
    check("R7 epc_we", {31'b0, epc_we}, 32'd1);
    check("R7 epc", epc_wdata, 32'h0000_1000);
    check("R2 code", {27'b0, cause_wdata[6:2]}, 32'd8);
    check("R7 bd", {31'b0, cause_wdata[31]}, 32'd0);
    check("R7 exl", {31'b0, exl_o}, 32'd1);
    @(negedge clk);
    check("R1 strobe one cycle", {31'b0, redirect}, 32'd0);
    check("R1 we drops", {31'b0, epc_we}, 32'd0);
    check("R1 ready back", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic t_delay_slot;
    issue(5'd9, 32'h0000_2004, 1'b1, 1'b0);
    check("R9 epc minus 4", epc_wdata, 32'h0000_2000);
    check("R7 bd set", {31'b0, cause_wdata[31]}, 32'd1);
  endtask

  task automatic t_refill;
    issue(5'd2, 32'h0000_3000, 1'b0, 1'b1);
    check("R4 refill load", new_pc, 32'h8000_0000);
    issue(5'd3, 32'h0000_3000, 1'b0, 1'b1);
    check("R4 refill store", new_pc, 32'h8000_0000);
    issue(5'd3, 32'h0000_3000, 1'b0, 1'b0);
    check("R4 invalid store general", new_pc, 32'h8000_0180);
    st_exl = 1'b1; cause_in = 32'h8000_0000;
    issue(5'd3, 32'h0000_3000, 1'b0, 1'b1);
    check("R4 refill with exl", new_pc, 32'h8000_0180);
    check("R8 no epc_we", {31'b0, epc_we}, 32'd0);
    check("R8 bd kept", {31'b0, cause_wdata[31]}, 32'd1);
    check("R8 exl stays", {31'b0, exl_o}, 32'd1);
    cause_in = 32'h0; st_exl = 1'b0;
  endtask

  task automatic t_base;
    st_bev = 1'b1;
    issue(5'd13, 32'h10, 1'b0, 1'b0);
    check("R3 bev base", new_pc, 32'hBFC0_0380);
    st_bev = 1'b0; ebase = 32'h1234_5678;
    issue(5'd13, 32'h10, 1'b0, 1'b0);
    check("R3 ebase low bits cleared", new_pc, 32'h1234_5580);
    ebase = 32'h8000_0000;
  endtask

  task automatic t_irq;
    issue(5'd0, 32'h40, 1'b0, 1'b0);
    check("R5 irq no iv", new_pc, 32'h8000_0180);
    cause_iv = 1'b1;
    issue(5'd0, 32'h40, 1'b0, 1'b0);
    check("R5 irq iv", new_pc, 32'h8000_0200);
    vec_en = 1'b1; vec_spacing = 5'd2;
    irq_pending = 8'b1010_0110; irq_mask = 8'b0010_0110;
    issue(5'd0, 32'h40, 1'b0, 1'b0);
    check("R6 vector 5 spacing 64", new_pc, 32'h8000_0340);
    irq_pending = 8'b0000_0001; irq_mask = 8'hFF;
    issue(5'd0, 32'h40, 1'b0, 1'b0);
    check("R6 line 0 gives vector 0", new_pc, 32'h8000_0200);
    cause_iv = 1'b0; vec_en = 1'b0; irq_pending = 0; irq_mask = 0;
  endtask

  task automatic t_cause_fields;
    cause_in = 32'h1000_FF00; cop_num = 2'd2;
    issue(5'd11, 32'h50, 1'b0, 1'b0);
    check("R12 ce field", {30'b0, cause_wdata[29:28]}, 32'd2);
    check("R2 cop code", {27'b0, cause_wdata[6:2]}, 32'd11);
    check("R2 other bits kept", cause_wdata & 32'h0FFF_FF83, 32'h0000_FF00);
    issue(5'd12, 32'h50, 1'b0, 1'b0);
    check("R12 ce copied for other kind", {30'b0, cause_wdata[29:28]}, 32'd1);
    check("R2 overflow code", {27'b0, cause_wdata[6:2]}, 32'd12);
    cause_in = 0; cop_num = 0;
  endtask

  task automatic t_nmi;
    st_exl = 1'b1;
    issue(5'd31, 32'h0000_7008, 1'b1, 1'b0);
    check("R10 nmi pc", new_pc, 32'hBFC0_0000);
    check("R10 errpc_we", {31'b0, errpc_we}, 32'd1);
    check("R10 errpc", errpc_wdata, 32'h0000_7004);
    check("R10 flags erl bev exl", {29'b0, erl_o, bev_o, exl_o}, 32'd7);
    check("R10 no epc/cause", {30'b0, epc_we, cause_we}, 32'd0);
    st_exl = 1'b0;
    issue(5'd31, 32'h0000_7008, 1'b0, 1'b0);
    check("R10 exl passthrough", {31'b0, exl_o}, 32'd0);
  endtask

  task automatic t_cache;
    st_bev = 1'b1;
    issue(5'd30, 32'h60, 1'b0, 1'b0);
    check("R11 cache bev", new_pc, 32'hBFC0_0300);
    check("R11 code", {27'b0, cause_wdata[6:2]}, 32'd30);
    st_bev = 1'b0;
    issue(5'd30, 32'h60, 1'b0, 1'b0);
    check("R11 cache ebase", new_pc, 32'hA000_0100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_syscall();
    t_delay_slot();
    t_refill();
    t_base();
    t_irq();
    t_cause_fields();
    t_nmi();
    t_cache();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule